// File: doc/BRIEF.md
# Split-Section Ripple Decimal Counter

The block is a four-bit counter built from two sections that run independently. A single-bit section divides its own clock by two. A multi-bit section steps through five states on a second clock. Each section advances on the falling edge of its own clock input, so the two sections can be chained outside the block in either order. Feeding the single-bit output into the second clock gives an 8-4-2-1 decimal count from 0 to 9. Feeding the top bit of the five-state section into the first clock gives a square wave at one tenth of the input rate, with equal high and low times.

The block has two gated override pairs. When both lines of the clear pair are high, every output goes to zero at once, with no clock edge needed. When both lines of the preset pair are high, the outputs take the pattern for nine, and the preset wins over the clear. While either override is in force, clock edges have no effect. When the overrides are released, counting picks up from the forced value.

Top module: `split_bcd_counter`

## Requirements
- R1: With no override in force, each falling edge of `clkLow` inverts `qLow`. `qHigh` is left as it is.
- R2: With no override in force, each falling edge of `clkHigh` advances `qHigh` in the order 0,1,2,3,4,0. `qLow` is left as it is.
- R3: `qHigh` never shows a code of 5 or above after a `clkHigh` edge. An unused code goes to 0 on the next edge.
- R4: With `clkHigh` driven from `qLow`, pulses on `clkLow` make {qHigh,qLow} run through the values 0 to 9 and then wrap to 0. Here qHigh[2] has weight 8, qHigh[1] weight 4, qHigh[0] weight 2 and qLow weight 1.
- R5: With `clkLow` driven from qHigh[2], `qLow` after n pulses on `clkHigh` from zero equals floor(n/5) mod 2. This gives a symmetric divide-by-ten.
- R6: When `clr0a` and `clr0b` are both high and the preset pair is not both high, {qHigh,qLow} is 0 at once, with no clock edge needed.
- R7: When `set9a` and `set9b` are both high, {qHigh,qLow} is 9 (qHigh=4, qLow=1) at once. This holds even while the clear pair is also both high.
- R8: While either override pair is fully high, falling clock edges leave the outputs unchanged. A single high line in a pair does not stop counting.
- R9: Rising edges on either clock have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkLow | input | 1 | Clock of the divide-by-two section, active on the falling edge |
| clkHigh | input | 1 | Clock of the divide-by-five section, active on the falling edge |
| clr0a | input | 1 | Clear-to-zero gate, first line |
| clr0b | input | 1 | Clear-to-zero gate, second line |
| set9a | input | 1 | Preset-to-nine gate, first line |
| set9b | input | 1 | Preset-to-nine gate, second line |
| qLow | output | 1 | Divide-by-two output (weight 1) |
| qHigh | output | HI_W (3) | Divide-by-five outputs (weights 2, 4, 8) |

## Verification
The properties stay disabled until the first clear or preset has been applied, because before that the flops hold no defined value. They also assume that override lines never change in the same instant as a falling clock edge. The stimulus always changes override lines half a bench period away from any clock fall. It switches the external chaining only while the clear is held and both candidate clock sources are low, so a mode change never makes a spurious falling edge.

// File: rtl/split_bcd_pkg.sv
package split_bcd_pkg;
  // strobes from the override decoder to the counting datapath
  typedef struct packed {
    logic clearAll;
    logic presetNine;
  } strobe_t;
endpackage

// File: rtl/split_bcd_control.sv
module split_bcd_control
  import split_bcd_pkg::*;
(
  input  logic    clr0a,
  input  logic    clr0b,
  input  logic    set9a,
  input  logic    set9b,
  output strobe_t ctl
);
  logic presetReq;
  logic clearReq;

  assign presetReq = set9a & set9b;
  assign clearReq  = clr0a & clr0b;

  // preset wins over clear
  always_comb begin
    ctl.presetNine = presetReq;
    ctl.clearAll   = clearReq & ~presetReq;
  end
endmodule

// File: rtl/split_bcd_datapath.sv
module split_bcd_datapath
  import split_bcd_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input  logic            clkLow,
  input  logic            clkHigh,
  input  strobe_t         ctl,
  output logic            qLow,
  output logic [HI_W-1:0] qHigh
);
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(HI_MOD - 1);

  logic            clrNow;
  logic            preNow;
  logic [HI_W-1:0] highNext;

  assign clrNow = ctl.clearAll;
  assign preNow = ctl.presetNine;

  generate
    if ((1 << HI_W) == HI_MOD) begin : g_wrapFree
      // every code is used: natural wrap
      assign highNext = qHigh + 1'b1;
    end else begin : g_wrapCmp
      // last state and all unused codes fall back to zero
      assign highNext = (qHigh >= HI_LAST) ? '0 : qHigh + 1'b1;
    end
  endgenerate

  always_ff @(negedge clkLow or posedge clrNow or posedge preNow) begin
    if (preNow)      qLow <= 1'b1;
    else if (clrNow) qLow <= 1'b0;
    else             qLow <= ~qLow;
  end

  always_ff @(negedge clkHigh or posedge clrNow or posedge preNow) begin
    if (preNow)      qHigh <= HI_LAST;
    else if (clrNow) qHigh <= '0;
    else             qHigh <= highNext;
  end
endmodule

// File: rtl/split_bcd_counter.sv
module split_bcd_counter
  import split_bcd_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input  logic            clkLow,
  input  logic            clkHigh,
  input  logic            clr0a,
  input  logic            clr0b,
  input  logic            set9a,
  input  logic            set9b,
  output logic            qLow,
  output logic [HI_W-1:0] qHigh
);
  strobe_t ctl;

  split_bcd_control u_ctl (
    .clr0a(clr0a), .clr0b(clr0b), .set9a(set9a), .set9b(set9b), .ctl(ctl)
  );

  split_bcd_datapath #(.HI_MOD(HI_MOD)) u_dp (
    .clkLow(clkLow), .clkHigh(clkHigh), .ctl(ctl), .qLow(qLow), .qHigh(qHigh)
  );
endmodule

// File: rtl/split_bcd_counter_chk.sv
module split_bcd_counter_chk #(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input logic            clkLow,
  input logic            clkHigh,
  input logic            clr0a,
  input logic            clr0b,
  input logic            set9a,
  input logic            set9b,
  input logic            qLow,
  input logic [HI_W-1:0] qHigh
);
  logic presetCond;
  logic clearCond;
  logic ovrCond;
  logic armed = 1'b0;
  logic dirtyLow;
  logic dirtyHigh;

  assign presetCond = set9a & set9b;
  assign clearCond  = clr0a & clr0b & ~presetCond;
  assign ovrCond    = (clr0a & clr0b) | presetCond;

  always_ff @(posedge ovrCond) armed <= 1'b1;

  // an override happened since the previous falling edge of that clock
  always_ff @(posedge ovrCond or negedge clkLow)
    if (ovrCond) dirtyLow <= 1'b1; else dirtyLow <= 1'b0;
  always_ff @(posedge ovrCond or negedge clkHigh)
    if (ovrCond) dirtyHigh <= 1'b1; else dirtyHigh <= 1'b0;

  AST_LOW_TOGGLE: assert property (@(negedge clkLow) disable iff (!armed)
    !ovrCond |=> (dirtyLow || ovrCond || qLow != $past(qLow)));  // R1

  AST_HIGH_STEP: assert property (@(negedge clkHigh) disable iff (!armed)
    !ovrCond |=> (dirtyHigh || ovrCond ||
      qHigh == (($past(qHigh) >= HI_W'(HI_MOD - 1)) ? '0 : $past(qHigh) + 1'b1)));  // R2

  AST_HIGH_LEGAL: assert property (@(negedge clkHigh) disable iff (!armed)
    qHigh < HI_W'(HI_MOD));  // R3

  AST_CLEAR_ZERO: assert property (@(negedge clkLow) disable iff (!armed)
    clearCond |-> (qLow == 1'b0 && qHigh == '0));  // R6

  AST_PRESET_NINE: assert property (@(negedge clkHigh) disable iff (!armed)
    presetCond |-> (qLow == 1'b1 && qHigh == HI_W'(HI_MOD - 1)));  // R7
endmodule

bind split_bcd_counter split_bcd_counter_chk #(.HI_MOD(HI_MOD)) u_chk (
  .clkLow(clkLow), .clkHigh(clkHigh), .clr0a(clr0a), .clr0b(clr0b),
  .set9a(set9a), .set9b(set9b), .qLow(qLow), .qHigh(qHigh)
);

// File: tb/split_bcd_counter_test.sv
module split_bcd_counter_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic lowManual = 1'b0, highManual = 1'b0;
  logic bcdMode = 1'b0, divTenMode = 1'b0;
  logic clr0a = 1'b0, clr0b = 1'b0, set9a = 1'b0, set9b = 1'b0;
  logic clkLow, clkHigh, qLow;
  logic [2:0] qHigh;
  logic [3:0] val;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // external chaining
  assign clkLow  = divTenMode ? qHigh[2] : lowManual;
  assign clkHigh = bcdMode ? qLow : highManual;
  assign val     = {qHigh, qLow};

  split_bcd_counter uut (
    .clkLow(clkLow), .clkHigh(clkHigh), .clr0a(clr0a), .clr0b(clr0b),
    .set9a(set9a), .set9b(set9b), .qLow(qLow), .qHigh(qHigh)
  );

  // {ctrl r0a r0b r9a r9b, pulse clkLow, expected value}
  localparam logic [8:0] VEC [21] = '{
    {4'b1100, 1'b0, 4'd0},
    {4'b0000, 1'b1, 4'd1}, {4'b0000, 1'b1, 4'd2}, {4'b0000, 1'b1, 4'd3},
    {4'b0000, 1'b1, 4'd4}, {4'b0000, 1'b1, 4'd5}, {4'b0000, 1'b1, 4'd6},
    {4'b0000, 1'b1, 4'd7}, {4'b0000, 1'b1, 4'd8}, {4'b0000, 1'b1, 4'd9},
    {4'b0000, 1'b1, 4'd0},
    {4'b0100, 1'b1, 4'd1}, {4'b0001, 1'b1, 4'd2}, {4'b1010, 1'b1, 4'd3},
    {4'b0011, 1'b0, 4'd9}, {4'b1111, 1'b0, 4'd9}, {4'b0011, 1'b1, 4'd9},
    {4'b0000, 1'b1, 4'd0}, {4'b0000, 1'b1, 4'd1}, {4'b1100, 1'b1, 4'd0},
    {4'b0000, 1'b0, 4'd0}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCtl(input logic [3:0] c);
    @(posedge clk);
    {clr0a, clr0b, set9a, set9b} = c;
    @(negedge clk);
  endtask

  task automatic pulseLow();
    @(posedge clk) lowManual = 1'b1;
    @(posedge clk) lowManual = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseHigh();
    @(posedge clk) highManual = 1'b1;
    @(posedge clk) highManual = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R6: clear with no clock edge gives the reset state
    setCtl(4'b1100);
    check("R6", val, 4'd0);
    setCtl(4'b0000);

    // R1: low section toggles alone
    for (int i = 1; i <= 3; i++) begin
      pulseLow();
      check("R1", val, {3'd0, 1'(i % 2)});
    end

    // R9: rising edge alone changes nothing
    @(posedge clk) lowManual = 1'b1;
    @(negedge clk);
    check("R9", val, 4'd1);
    @(posedge clk) lowManual = 1'b0;
    @(negedge clk);
    check("R1", val, 4'd0);
    @(posedge clk) highManual = 1'b1;
    @(negedge clk);
    check("R9", val, 4'd0);
    @(posedge clk) highManual = 1'b0;
    @(negedge clk);
    check("R2", val, {3'd1, 1'b0});

    // R2, R3: high section walks 0..4 and wraps
    for (int i = 2; i <= 8; i++) begin
      pulseHigh();
      check("R2", val, {3'(i % 5), 1'b0});
      check("R3", {1'b0, (qHigh < 3'd5) ? 3'd1 : 3'd0}, 4'd1);
    end

    // R4, R6, R7, R8: decimal chain, table driven
    setCtl(4'b1100);
    bcdMode = 1'b1;
    foreach (VEC[k]) begin
      logic [3:0] c;
      string tag;
      c = VEC[k][8:5];
      setCtl(c);
      if (VEC[k][4]) pulseLow();
      if (c[1:0] == 2'b11) tag = VEC[k][4] ? "R8" : "R7";
      else if (c[3:2] == 2'b11) tag = VEC[k][4] ? "R8" : "R6";
      else tag = "R4";
      check(tag, val, VEC[k][3:0]);
    end

    // R5: symmetric divide by ten
    setCtl(4'b1100);
    bcdMode = 1'b0;
    divTenMode = 1'b1;
    setCtl(4'b0000);
    for (int n = 1; n <= 20; n++) begin
      pulseHigh();
      check("R5", {3'd0, qLow}, {3'd0, 1'((n / 5) % 2)});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule